// File: doc/BRIEF.md
# LIN Receiver Status Flag Unit

This block keeps the error and status flags of a serial receiver that can run as a LIN master or a LIN slave. The receive datapath hands it one-cycle strobes: a finished character with its data byte and stop bit, a header timeout, a broken sync field, an overrun, a noise sample and an identifier parity result. The unit turns these into a sticky 8-bit status byte, a separate break/header flag, a sync-lock bit and two interrupt requests, one for receive and one for parity.

Software reads the block over a small register bus with three readable locations. Address 0 is the status byte, address 1 is the last received byte, and address 2 is an auxiliary byte with the sync lock in bit 0 and the break flag in bit 1. Status flags are cleared by the usual two-step access: read the status byte, then read the data byte. A flag that sets between those two reads survives. The sync lock keeps the header-error flag from clearing until software has released the lock through the auxiliary register.

Status byte layout: bits 7 and 6 read 1 (transmit-side indications, out of scope, tied high), bit 5 is received-data-ready, bit 4 reads 0, bit 3 is header error, bit 2 is noise, bit 1 is framing error and bit 0 is parity error.

Top module: `lin_rx_flags`

## Requirements
- R1: After reset the status byte reads 8'hC0, the auxiliary byte reads 8'h00 and both interrupt requests are low.
- R2: Header error (status bit 3) sets on a bad sync field, on an overrun in any phase, and on a timeout only while the header-phase input is 1. A bad sync field also sets the sync lock (auxiliary bit 0).
- R3: While the sync lock is 1, the clear sequence leaves status bit 3 set. Writing a byte with bit 0 = 1 to address 2 clears the lock, and a clear sequence after that clears bit 3.
- R4: In slave mode, framing error (status bit 1) sets only for a character whose stop bit is 0 and whose data byte is not all zero.
- R5: In slave mode a break (data 8'h00 with stop bit 0) sets the break flag (auxiliary bit 1) unless break detection is switched off. Writing bit 1 = 1 to address 2 clears it. The status clear sequence does not touch it. In master mode any stop bit of 0 sets framing error and the break flag stays 0.
- R6: Parity error (status bit 0) sets on an identifier parity failure only while parity checking is enabled. The parity interrupt equals parity error AND parity interrupt enable.
- R7: The receive interrupt is high when the receive interrupt enable is 1 and status bit 3 or status bit 5 is set.
- R8: The noise flag (status bit 2) sets on a noise strobe in master mode only. In slave mode the strobe has no effect.
- R9: A read of address 1 clears status bits 5 to 0 only when a read of address 0 came before it with no disarming event in between. A data read without that prior status read changes nothing.
- R10: A write to address 0, or any flag-setting event, after the status read disarms the sequence. The following data read then clears nothing.
- R11: When a flag sets in the same cycle as a clearing data read, that flag reads 1 afterwards while the other flags clear.
- R12: Every completed character sets status bit 5 and loads its byte into the data register at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 1 = slave mode, 0 = master mode |
| cfg_brk_off | input | 1 | 1 = break-as-header detection switched off |
| cfg_par_chk | input | 1 | Identifier parity checking enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_par_ie | input | 1 | Parity interrupt enable |
| ev_frame | input | 1 | Character completed strobe |
| ev_data | input | 8 | Data byte of the completed character |
| ev_stop | input | 1 | Sampled stop bit of the completed character |
| ev_in_hdr | input | 1 | Header reception in progress |
| ev_timeout | input | 1 | Header timeout strobe |
| ev_sync_bad | input | 1 | Corrupted sync field strobe |
| ev_overrun | input | 1 | Overrun strobe |
| ev_noise | input | 1 | Noise detected strobe |
| ev_id_chk | input | 1 | Identifier parity result valid |
| ev_id_bad | input | 1 | Identifier parity mismatch (with ev_id_chk) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 status, 1 data, 2 auxiliary) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_par | output | 1 | Parity interrupt request |

## Verification
All flags, the data register, the sync lock and the arm state are one register stage behind their inputs. A strobe driven for one cycle is therefore visible on bus_rdata and on the interrupt outputs from the rising edge that samples it. Read data is combinational from the address, so it holds the value of the current cycle. The bench drives every input at a falling edge, lets one rising edge pass, and samples results at the next falling edge, or 1 ns after it sets a read address. Same-cycle cases, such as a set event that coincides with the clearing data read, are driven within one clock cycle, so the race is the one the requirement describes.

// File: rtl/lin_flags_pkg.sv
package lin_flags_pkg;

  localparam int STAT_W  = 8;
  localparam int FRAME_W = 8;
  localparam int ADDR_W  = 2;

  // status byte bit positions (software decodes these)
  localparam int B_TXE = 7;
  localparam int B_TXC = 6;
  localparam int B_RDY = 5;
  localparam int B_HDR = 3;
  localparam int B_NF  = 2;
  localparam int B_FE  = 1;
  localparam int B_PE  = 0;

  // auxiliary byte bit positions
  localparam int A_LOCK = 0;
  localparam int A_BRK  = 1;

  // sticky line-flag vector indices inside the line error module
  localparam int LF_PE  = 0;
  localparam int LF_FE  = 1;
  localparam int LF_NF  = 2;
  localparam int LF_RDY = 3;
  localparam int LF_N   = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_DATA = 2'd1,
    REG_AUX  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // all-zero character with a dominant stop bit
  function automatic logic is_break(input logic [FRAME_W-1:0] d, input logic stop);
    return (d == '0) && !stop;
  endfunction

  // a genuine framing error: slave mode wants some recessive data bit too
  function automatic logic true_fe(input logic [FRAME_W-1:0] d, input logic stop,
                                   input logic slave);
    return !stop && (!slave || (d != '0));
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic rdy, input logic hdr,
                                                    input logic nf, input logic fe,
                                                    input logic pe);
    logic [STAT_W-1:0] s;
    s        = '0;
    s[B_TXE] = 1'b1;
    s[B_TXC] = 1'b1;
    s[B_RDY] = rdy;
    s[B_HDR] = hdr;
    s[B_NF]  = nf;
    s[B_FE]  = fe;
    s[B_PE]  = pe;
    return s;
  endfunction

endpackage

// File: rtl/lin_seq_clear.sv
module lin_seq_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic data_rd,
  input  logic any_set,
  output logic armed,
  output logic clr
);

  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (any_set || stat_wr) armed_d = 1'b0;
    else if (stat_rd)       armed_d = 1'b1;
    else if (data_rd)       armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;
  assign clr   = armed_q && data_rd;

  // R10: a set event or status write leaves the sequence disarmed
  assert_disarm_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_set || stat_wr) |=> !armed_q);

  // R9: the sequence only arms from a status read
  assert_arm_from_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !stat_rd) |=> !armed_q);

endmodule

// File: rtl/lin_hdr_err.sv
module lin_hdr_err (
  input  logic clk,
  input  logic rst_n,
  input  logic in_hdr,
  input  logic timeout,
  input  logic sync_bad,
  input  logic overrun,
  input  logic clr,
  input  logic lock_clr,
  output logic hdr_q,
  output logic lock_q,
  output logic hdr_set
);

  assign hdr_set = sync_bad || overrun || (timeout && in_hdr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (sync_bad) begin
      lock_q <= 1'b1;
    end else if (lock_clr) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= 1'b0;
    end else if (hdr_set) begin
      hdr_q <= 1'b1;
    end else if (clr && !lock_q) begin
      hdr_q <= 1'b0;
    end
  end

  // R2: a bad sync field raises both the error and the lock
  assert_sync_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_bad |=> (hdr_q && lock_q));

  // R2: a timeout outside the header alone sets nothing
  assert_timeout_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_q && timeout && !in_hdr && !sync_bad && !overrun) |=> !hdr_q);

  // R3: the lock holds the header error
  assert_lock_holds_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && hdr_q) |=> hdr_q);

endmodule

// File: rtl/lin_line_err.sv
module lin_line_err
  import lin_flags_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slave,
  input  logic               brk_off,
  input  logic               par_chk,
  input  logic               frame,
  input  logic [FRAME_W-1:0] data,
  input  logic               stop,
  input  logic               noise,
  input  logic               id_chk,
  input  logic               id_bad,
  input  logic               clr,
  input  logic               brk_clr,
  output logic [LF_N-1:0]    flags_q,
  output logic               brk_q,
  output logic [FRAME_W-1:0] data_q,
  output logic               any_set
);

  logic [LF_N-1:0] set_vec;
  logic            brk_set;

  assign set_vec[LF_PE]  = id_chk && id_bad && par_chk;
  assign set_vec[LF_FE]  = frame && true_fe(data, stop, slave);
  assign set_vec[LF_NF]  = noise && !slave;
  assign set_vec[LF_RDY] = frame;
  assign brk_set         = frame && slave && !brk_off && is_break(data, stop);
  assign any_set         = (|set_vec) || brk_set;

  for (genvar i = 0; i < LF_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (set_vec[i]) flags_q[i] <= 1'b1;
      else if (clr)        flags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_q <= 1'b0;
    else if (brk_set) brk_q <= 1'b1;
    else if (brk_clr) brk_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (frame) data_q <= data;
  end

  // R4: a slave-mode break never becomes a framing error
  assert_fe_not_on_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && !flags_q[LF_FE] && (data == '0)) |=> !flags_q[LF_FE]);

  // R5: the break flag stays clear in master mode
  assert_no_brk_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !brk_q) |=> !brk_q);

  // R6: parity error needs the check enabled
  assert_pe_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_chk && !flags_q[LF_PE]) |=> !flags_q[LF_PE]);

  // R8: slave-mode noise is ignored
  assert_noise_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && !flags_q[LF_NF]) |=> !flags_q[LF_NF]);

  // R11: a set in the clearing cycle wins
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && id_chk && id_bad && par_chk) |=> flags_q[LF_PE]);

  // R12: each character loads its byte and raises data-ready
  assert_frame_loads_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> (flags_q[LF_RDY] && (data_q == $past(data))));

endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags
  import lin_flags_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_slave,
  input  logic               cfg_brk_off,
  input  logic               cfg_par_chk,
  input  logic               cfg_rx_ie,
  input  logic               cfg_par_ie,
  input  logic               ev_frame,
  input  logic [FRAME_W-1:0] ev_data,
  input  logic               ev_stop,
  input  logic               ev_in_hdr,
  input  logic               ev_timeout,
  input  logic               ev_sync_bad,
  input  logic               ev_overrun,
  input  logic               ev_noise,
  input  logic               ev_id_chk,
  input  logic               ev_id_bad,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [STAT_W-1:0]  bus_wdata,
  output logic [STAT_W-1:0]  bus_rdata,
  output logic               irq_rx,
  output logic               irq_par
);

  reg_sel_e sel;
  logic stat_rd, stat_wr, data_rd, aux_wr;
  logic armed, clr;
  logic hdr_q, lock_q, hdr_set;
  logic [LF_N-1:0] lflags;
  logic brk_q, line_set, any_set;
  logic [FRAME_W-1:0] data_q;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] aux;
  logic unused_wbits;

  assign sel     = reg_sel_e'(bus_addr);
  assign stat_rd = bus_sel && !bus_wr && (sel == REG_STAT);
  assign stat_wr = bus_sel &&  bus_wr && (sel == REG_STAT);
  assign data_rd = bus_sel && !bus_wr && (sel == REG_DATA);
  assign aux_wr  = bus_sel &&  bus_wr && (sel == REG_AUX);
  assign any_set = hdr_set || line_set;
  assign unused_wbits = ^bus_wdata[STAT_W-1:2];

  lin_seq_clear u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .data_rd (data_rd),
    .any_set (any_set),
    .armed   (armed),
    .clr     (clr)
  );

  lin_hdr_err u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_hdr   (ev_in_hdr),
    .timeout  (ev_timeout),
    .sync_bad (ev_sync_bad),
    .overrun  (ev_overrun),
    .clr      (clr),
    .lock_clr (aux_wr && bus_wdata[A_LOCK]),
    .hdr_q    (hdr_q),
    .lock_q   (lock_q),
    .hdr_set  (hdr_set)
  );

  lin_line_err u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .slave   (cfg_slave),
    .brk_off (cfg_brk_off),
    .par_chk (cfg_par_chk),
    .frame   (ev_frame),
    .data    (ev_data),
    .stop    (ev_stop),
    .noise   (ev_noise),
    .id_chk  (ev_id_chk),
    .id_bad  (ev_id_bad),
    .clr     (clr),
    .brk_clr (aux_wr && bus_wdata[A_BRK]),
    .flags_q (lflags),
    .brk_q   (brk_q),
    .data_q  (data_q),
    .any_set (line_set)
  );

  assign status = pack_status(lflags[LF_RDY], hdr_q, lflags[LF_NF],
                              lflags[LF_FE], lflags[LF_PE]);

  always_comb begin
    aux         = '0;
    aux[A_LOCK] = lock_q;
    aux[A_BRK]  = brk_q;
  end

  always_comb begin
    unique case (sel)
      REG_STAT: bus_rdata = status;
      REG_DATA: bus_rdata = STAT_W'(data_q);
      REG_AUX:  bus_rdata = aux;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_rx  = cfg_rx_ie  && (hdr_q || lflags[LF_RDY]);
  assign irq_par = cfg_par_ie && lflags[LF_PE];

  // R9: an unarmed data read leaves the framing flag alone
  assert_clear_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !armed && status[B_FE]) |=> status[B_FE]);

  // R5: the status clear sequence does not touch the break flag
  assert_brk_survives_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && brk_q && !aux_wr) |=> brk_q);

endmodule

// File: tb/sim_lin_rx_flags.sv
module sim_lin_rx_flags;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_slave = 0, cfg_brk_off = 0, cfg_par_chk = 0, cfg_rx_ie = 0, cfg_par_ie = 0;
  logic       ev_frame = 0, ev_stop = 1, ev_in_hdr = 0, ev_timeout = 0, ev_sync_bad = 0;
  logic       ev_overrun = 0, ev_noise = 0, ev_id_chk = 0, ev_id_bad = 0;
  logic [7:0] ev_data = '0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_rx, irq_par;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  lin_rx_flags u0 (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic clear_seq();
    logic [7:0] v;
    rd(2'd0, v);
    rd(2'd1, v);
  endtask

  task automatic frame(input logic [7:0] d, input logic s);
    @(negedge clk);
    ev_frame = 1; ev_data = d; ev_stop = s;
    @(negedge clk);
    ev_frame = 0; ev_stop = 1;
  endtask

  task automatic strobe(input int kind);
    @(negedge clk);
    case (kind)
      0: ev_timeout = 1;
      1: ev_sync_bad = 1;
      2: ev_overrun = 1;
      3: ev_noise = 1;
      default: begin ev_id_chk = 1; ev_id_bad = 1; end
    endcase
    @(negedge clk);
    ev_timeout = 0; ev_sync_bad = 0; ev_overrun = 0; ev_noise = 0;
    ev_id_chk = 0; ev_id_bad = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 status", bus_rdata, 8'hC0);
    chk_reg("R1 aux", 2'd2, 8'h00);
    check("R1 irq", {6'b0, irq_rx, irq_par}, 8'h00);
  endtask

  task automatic t_slave_fe();
    cfg_slave = 1;
    frame(8'h10, 1'b0);
    chk_reg("R4 fe on real error", 2'd0, 8'hE2);
    chk_reg("R12 data byte", 2'd1, 8'h10);
    clear_seq();
    chk_reg("R9 cleared", 2'd0, 8'hC0);
    frame(8'h00, 1'b1);
    chk_reg("R4 zero byte good stop", 2'd0, 8'hE0);
    clear_seq();
  endtask

  task automatic t_break();
    cfg_slave = 1; cfg_brk_off = 0;
    frame(8'h00, 1'b0);
    chk_reg("R4 break no fe", 2'd0, 8'hE0);
    chk_reg("R5 break flag", 2'd2, 8'h02);
    clear_seq();
    chk_reg("R5 brk survives clear", 2'd2, 8'h02);
    wr(2'd2, 8'h02);
    chk_reg("R5 brk write clear", 2'd2, 8'h00);
    cfg_brk_off = 1;
    frame(8'h00, 1'b0);
    chk_reg("R5 brk off", 2'd2, 8'h00);
    clear_seq();
    cfg_brk_off = 0; cfg_slave = 0;
    frame(8'h00, 1'b0);
    chk_reg("R5 master break is fe", 2'd0, 8'hE2);
    chk_reg("R5 master no brk", 2'd2, 8'h00);
    clear_seq();
  endtask

  task automatic t_header();
    ev_in_hdr = 0;
    strobe(0);
    chk_reg("R2 timeout outside header", 2'd0, 8'hC0);
    ev_in_hdr = 1;
    strobe(0);
    chk_reg("R2 timeout in header", 2'd0, 8'hC8);
    clear_seq();
    ev_in_hdr = 0;
    strobe(2);
    chk_reg("R2 overrun", 2'd0, 8'hC8);
    clear_seq();
    chk_reg("R9 hdr cleared", 2'd0, 8'hC0);
    strobe(1);
    chk_reg("R2 sync bad", 2'd0, 8'hC8);
    chk_reg("R2 lock set", 2'd2, 8'h01);
    clear_seq();
    chk_reg("R3 locked hdr stays", 2'd0, 8'hC8);
    wr(2'd2, 8'h01);
    chk_reg("R3 lock released", 2'd2, 8'h00);
    chk_reg("R3 hdr still set", 2'd0, 8'hC8);
    clear_seq();
    chk_reg("R3 hdr cleared after unlock", 2'd0, 8'hC0);
  endtask

  task automatic t_parity();
    cfg_par_chk = 0; cfg_par_ie = 1;
    strobe(4);
    chk_reg("R6 parity disabled", 2'd0, 8'hC0);
    check("R6 no irq", {7'b0, irq_par}, 8'h00);
    cfg_par_chk = 1; cfg_par_ie = 0;
    strobe(4);
    chk_reg("R6 parity enabled", 2'd0, 8'hC1);
    check("R6 irq masked", {7'b0, irq_par}, 8'h00);
    cfg_par_ie = 1;
    #1 check("R6 irq raised", {7'b0, irq_par}, 8'h01);
    clear_seq();
    #1 check("R6 irq gone", {7'b0, irq_par}, 8'h00);
    cfg_par_ie = 0; cfg_par_chk = 0;
  endtask

  task automatic t_noise();
    cfg_slave = 1;
    strobe(3);
    chk_reg("R8 slave noise ignored", 2'd0, 8'hC0);
    cfg_slave = 0;
    strobe(3);
    chk_reg("R8 master noise", 2'd0, 8'hC4);
    clear_seq();
  endtask

  task automatic t_rx_irq();
    cfg_rx_ie = 1;
    #1 check("R7 idle", {7'b0, irq_rx}, 8'h00);
    frame(8'h5A, 1'b1);
    #1 check("R7 on data ready", {7'b0, irq_rx}, 8'h01);
    clear_seq();
    #1 check("R7 cleared", {7'b0, irq_rx}, 8'h00);
    strobe(2);
    #1 check("R7 on header error", {7'b0, irq_rx}, 8'h01);
    clear_seq();
    cfg_rx_ie = 0;
    strobe(2);
    #1 check("R7 masked", {7'b0, irq_rx}, 8'h00);
    clear_seq();
  endtask

  task automatic t_no_arm();
    logic [7:0] v;
    strobe(3);
    rd(2'd1, v);
    chk_reg("R9 data read alone", 2'd0, 8'hC4);
    rd(2'd1, v);
    chk_reg("R9 clear after status read", 2'd1, 8'h5A);
    chk_reg("R9 status after clear", 2'd0, 8'hC0);
  endtask

  task automatic t_disarm();
    logic [7:0] v;
    frame(8'h55, 1'b0);
    rd(2'd0, v);
    strobe(3);
    rd(2'd1, v);
    chk_reg("R10 event disarms", 2'd0, 8'hE6);
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    chk_reg("R10 status write disarms", 2'd0, 8'hE6);
    clear_seq();
    chk_reg("R10 later clear works", 2'd0, 8'hC0);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    strobe(3);
    cfg_par_chk = 1;
    rd(2'd0, v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'd1; ev_id_chk = 1; ev_id_bad = 1;
    @(negedge clk);
    bus_sel = 0; ev_id_chk = 0; ev_id_bad = 0;
    chk_reg("R11 set wins", 2'd0, 8'hC1);
    clear_seq();
    cfg_par_chk = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_slave_fe();
    t_break();
    t_header();
    t_parity();
    t_noise();
    t_rx_irq();
    t_no_arm();
    t_disarm();
    t_set_wins();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule